// File: doc/BRIEF.md
# Integer ALU with Condition Flags and Overflow Trap

This block is a 32-bit integer arithmetic/logic unit for a processor datapath. It takes two operands and a 4-bit operation code and returns the result on the same cycle, with no register in that path. The operations are two's-complement add and subtract, an add and a subtract that never trap, bitwise AND, OR and NOR, and logical shifts left and right.

Alongside the result, the block keeps a registered set of condition flags: sign, zero, carry and parity. It also keeps a registered overflow-trap request. These five bits update on a rising clock edge only when `in_valid` is high, and they hold their value otherwise. A later branch or exception stage can then read them. The trapping add and subtract raise the trap request on signed overflow. No other operation raises it.

Top module: `cc_alu`

## Requirements
- R1: Opcode 0 (add) and opcode 2 (non-trapping add) give `result` = `a` + `b` modulo 2^32. Opcode 1 (subtract) and opcode 3 (non-trapping subtract) give `result` = `a` + ~`b` + 1 modulo 2^32, which is `a` − `b`. The result is combinational.
- R2: Opcode 4 gives `a` AND `b`, opcode 5 gives `a` OR `b`, and opcode 6 gives NOT(`a` OR `b`).
- R3: Opcode 7 shifts `a` left logically and opcode 8 shifts `a` right logically. The shift amount is `b[4:0]`, and bits 31:5 of `b` are ignored.
- R4: On a valid cycle, `flag_sign_q` becomes bit 31 of the result. `flag_zero_q` becomes 1 exactly when all 32 result bits are 0.
- R5: On a valid cycle, `flag_parity_q` becomes 1 when `result[7:0]` holds an even number of ones, and 0 otherwise. Bits 31:8 of the result do not affect it.
- R6: On a valid cycle, `flag_carry_q` is set as follows:
  - For opcodes 0 and 2 it is the carry out of bit 31.
  - For opcodes 1 and 3 it is the carry out of `a` + ~`b` + 1, so it is 1 when `a` ≥ `b` unsigned (no borrow).
  - For every other opcode it is 0.
- R7: On a valid cycle with opcode 0 or 1, `trap_q` becomes 1 exactly when the signed result overflows.
  - An add overflows when both operands have the same sign and the result has the other sign.
  - A subtract overflows when the operands have different signs and the result's sign differs from `a`.
  - An add of operands with different signs never traps.
- R8: On a valid cycle with any opcode other than 0 or 1, `trap_q` becomes 0, even when the unsigned result wraps.
- R9: When `in_valid` is 0, all five registered outputs keep their previous values at the clock edge.
- R10: A synchronous active-high `rst` clears all five registered outputs to 0 at the next rising edge, and it takes priority over `in_valid`.
- R11: Opcodes 9 to 15 give `result` = 0. On a valid cycle they load zero = 1, parity = 1, sign = 0, carry = 0 and trap = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the flag registers |
| in_valid | input | 1 | Loads the flags and trap from the current operation |
| op | input | 4 | Operation code (see R1, R2, R3 and R11) |
| a | input | 32 | First operand |
| b | input | 32 | Second operand; shift amount in bits 4:0 |
| result | output | 32 | Combinational operation result |
| flag_sign_q | output | 1 | Registered sign flag |
| flag_zero_q | output | 1 | Registered zero flag |
| flag_carry_q | output | 1 | Registered carry / no-borrow flag |
| flag_parity_q | output | 1 | Registered even-parity flag of result bits 7:0 |
| trap_q | output | 1 | Registered overflow-trap request |

## Verification
The bench targets the four signed-overflow edges: max positive + 1, most negative + most negative, max positive − (−1), and most negative − 1. A design with a wrong sign rule would either miss these traps or raise traps on mixed-sign adds. It also runs the same operands through the non-trapping forms, where a design that shares the trap path would request a trap on plain address arithmetic. For subtract, it checks carry on equal operands and on 0 − 1, where an inverted borrow convention shows up at once. It also applies results whose upper bytes carry extra ones, which would break a parity taken over the whole word. Shift amounts with set upper bits, invalid cycles and a reset coinciding with a valid overflowing operation are checked as well: respectively, these catch a wide shift decode, flags that load without `in_valid`, and a reset that loses priority.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;

    localparam int unsigned OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_ADDU = 4'd2,
        OP_SUBU = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_NOR  = 4'd6,
        OP_SLL  = 4'd7,
        OP_SRL  = 4'd8
    } alu_op_e;

    typedef struct packed {
        logic sign;
        logic zero;
        logic carry;
        logic parity;
        logic trap;
    } cc_state_t;

endpackage

// File: rtl/cc_alu_addsub.sv
module cc_alu_addsub #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             ovf
);
    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide;

    always_comb begin
        b_eff     = sub ? ~b : b;
        wide      = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
        sum       = wide[WIDTH-1:0];
        carry_out = wide[WIDTH];
        // same-sign inputs to the adder with a sign change in the sum
        ovf       = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/cc_alu_bitops.sv
module cc_alu_bitops
    import cc_alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] res
);
    localparam int unsigned SHAMT_W = $clog2(WIDTH);

    logic [SHAMT_W-1:0] shamt;

    always_comb begin
        shamt = b[SHAMT_W-1:0];
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_NOR:  res = ~(a | b);
            OP_SLL:  res = a << shamt;
            OP_SRL:  res = a >> shamt;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/cc_alu_flaggen.sv
module cc_alu_flaggen #(
    parameter int unsigned WIDTH    = 32,
    parameter int unsigned PAR_BITS = 8
) (
    input  logic [WIDTH-1:0] res,
    output logic             sign,
    output logic             zero,
    output logic             parity
);
    localparam int unsigned PW = (PAR_BITS < WIDTH) ? PAR_BITS : WIDTH;

    logic [PW-1:0] low_bits;

    always_comb begin
        low_bits = res[PW-1:0];
        sign     = res[WIDTH-1];
        zero     = (res == '0);
        parity   = ~(^low_bits);
    end
endmodule

// File: rtl/cc_alu.sv
module cc_alu
    import cc_alu_pkg::*;
#(
    parameter int unsigned WIDTH    = 32,
    parameter int unsigned PAR_BITS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] result,
    output logic             flag_sign_q,
    output logic             flag_zero_q,
    output logic             flag_carry_q,
    output logic             flag_parity_q,
    output logic             trap_q
);
    alu_op_e    op_e;
    logic       is_sub;
    logic [WIDTH-1:0] sum;
    logic       add_carry;
    logic       add_ovf;
    logic [WIDTH-1:0] bit_res;
    logic       f_sign;
    logic       f_zero;
    logic       f_parity;
    cc_state_t  cc_d;
    cc_state_t  cc_q;
    logic       carry_d;
    logic       trap_d;

    assign op_e   = alu_op_e'(op);
    assign is_sub = (op_e == OP_SUB) || (op_e == OP_SUBU);

    cc_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a        (a),
        .b        (b),
        .sub      (is_sub),
        .sum      (sum),
        .carry_out(add_carry),
        .ovf      (add_ovf)
    );

    cc_alu_bitops #(.WIDTH(WIDTH)) u_bitops (
        .op (op_e),
        .a  (a),
        .b  (b),
        .res(bit_res)
    );

    cc_alu_flaggen #(.WIDTH(WIDTH), .PAR_BITS(PAR_BITS)) u_flaggen (
        .res   (result),
        .sign  (f_sign),
        .zero  (f_zero),
        .parity(f_parity)
    );

    always_comb begin
        result  = '0;
        carry_d = 1'b0;
        trap_d  = 1'b0;
        case (op_e)
            OP_ADD, OP_SUB: begin
                result  = sum;
                carry_d = add_carry;
                trap_d  = add_ovf;
            end
            OP_ADDU, OP_SUBU: begin
                result  = sum;
                carry_d = add_carry;
            end
            OP_AND, OP_OR, OP_NOR, OP_SLL, OP_SRL: begin
                result  = bit_res;
            end
            default: result = '0;
        endcase

        cc_d = cc_q;
        if (in_valid) begin
            cc_d.sign   = f_sign;
            cc_d.zero   = f_zero;
            cc_d.carry  = carry_d;
            cc_d.parity = f_parity;
            cc_d.trap   = trap_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cc_q <= '0;
        end else begin
            cc_q <= cc_d;
        end
    end

    assign flag_sign_q   = cc_q.sign;
    assign flag_zero_q   = cc_q.zero;
    assign flag_carry_q  = cc_q.carry;
    assign flag_parity_q = cc_q.parity;
    assign trap_q        = cc_q.trap;
endmodule

// File: rtl/cc_alu_checker.sv
module cc_alu_checker #(
    parameter int unsigned WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [3:0]       op,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic [WIDTH-1:0] result,
    input logic             flag_sign_q,
    input logic             flag_zero_q,
    input logic             flag_carry_q,
    input logic             flag_parity_q,
    input logic             trap_q
);
    localparam int unsigned MSB = WIDTH - 1;

    AST_SIGN_TRACKS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (flag_sign_q == $past(result[MSB])));                                   // R4

    AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (flag_zero_q == ($past(result) == '0)));                                 // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(flag_sign_q) && $stable(flag_zero_q) && $stable(flag_carry_q)
                       && $stable(flag_parity_q) && $stable(trap_q)));                       // R9

    AST_NO_TRAP_UNSIGNED: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op > 4'd1)) |=> !trap_q);                                              // R8

    AST_NO_CARRY_BITOPS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op > 4'd3)) |=> !flag_carry_q);                                        // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == 4'd0) && (a[MSB] != b[MSB])) |=> !trap_q);                       // R7

    AST_SUB_SAME_SIGN: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == 4'd1) && (a[MSB] == b[MSB])) |=> !trap_q);                       // R7
endmodule

bind cc_alu cc_alu_checker #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .op           (op),
    .a            (a),
    .b            (b),
    .result       (result),
    .flag_sign_q  (flag_sign_q),
    .flag_zero_q  (flag_zero_q),
    .flag_carry_q (flag_carry_q),
    .flag_parity_q(flag_parity_q),
    .trap_q       (trap_q)
);

// File: tb/cc_alu_bench.sv
module cc_alu_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [31:0] result;
    logic        flag_sign_q, flag_zero_q, flag_carry_q, flag_parity_q, trap_q;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // model registers: sign, zero, carry, parity, trap
    logic m_sign = 0, m_zero = 0, m_carry = 0, m_par = 0, m_trap = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cc_alu u_cc_alu (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .a(a), .b(b),
        .result(result), .flag_sign_q(flag_sign_q), .flag_zero_q(flag_zero_q),
        .flag_carry_q(flag_carry_q), .flag_parity_q(flag_parity_q), .trap_q(trap_q)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (op=%0d a=%h b=%h)", tag, what, act, exp, op, a, b);
        end
    endtask

    function automatic void model(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                                  output logic [31:0] r, output logic c, output logic t);
        longint sx = longint'($signed(x));
        longint sy = longint'($signed(y));
        longint ux = longint'({32'd0, x});
        longint uy = longint'({32'd0, y});
        longint s;
        r = '0; c = 0; t = 0;
        case (o)
            4'd0, 4'd2: begin
                r = x + y;
                c = (ux + uy) > 64'sd4294967295;
                s = sx + sy;
                t = (o == 4'd0) && (s > 64'sd2147483647 || s < -64'sd2147483648);
            end
            4'd1, 4'd3: begin
                r = x - y;
                c = (ux >= uy);
                s = sx - sy;
                t = (o == 4'd1) && (s > 64'sd2147483647 || s < -64'sd2147483648);
            end
            4'd4: r = x & y;
            4'd5: r = x | y;
            4'd6: r = ~(x | y);
            4'd7: r = x << y[4:0];
            4'd8: r = x >> y[4:0];
            default: r = '0;
        endcase
    endfunction

    function automatic string res_tag(input logic [3:0] o);
        if (o <= 4'd3) return "R1";
        if (o <= 4'd6) return "R2";
        if (o <= 4'd8) return "R3";
        return "R11";
    endfunction

    task automatic check_flags(input string hold_tag);
        check(hold_tag == "" ? "R4" : hold_tag, "sign",   {31'd0, flag_sign_q},   {31'd0, m_sign});
        check(hold_tag == "" ? "R4" : hold_tag, "zero",   {31'd0, flag_zero_q},   {31'd0, m_zero});
        check(hold_tag == "" ? "R6" : hold_tag, "carry",  {31'd0, flag_carry_q},  {31'd0, m_carry});
        check(hold_tag == "" ? "R5" : hold_tag, "parity", {31'd0, flag_parity_q}, {31'd0, m_par});
        check(hold_tag == "" ? (op <= 4'd1 ? "R7" : "R8") : hold_tag, "trap",
              {31'd0, trap_q}, {31'd0, m_trap});
    endtask

    task automatic apply(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y, input logic v);
        logic [31:0] r;
        logic c, t;
        int ones;
        @(negedge clk);
        op = o; a = x; b = y; in_valid = v;
        #1;
        model(o, x, y, r, c, t);
        check(res_tag(o), "result", result, r);
        if (v) begin
            ones = 0;
            for (int i = 0; i < 8; i++) ones += int'(r[i]);
            m_sign = r[31]; m_zero = (r == 0); m_carry = c; m_par = (ones % 2 == 0); m_trap = t;
        end
        @(posedge clk);
        #1;
        check_flags(v ? "" : "R9");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        check("R10", "reset flags", {27'd0, flag_sign_q, flag_zero_q, flag_carry_q, flag_parity_q, trap_q}, 32'd0);

        // R7 signed overflow edges
        apply(4'd0, 32'h7FFF_FFFF, 32'h0000_0001, 1);
        apply(4'd0, 32'h8000_0000, 32'h8000_0000, 1);
        apply(4'd0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1);
        apply(4'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1);
        apply(4'd1, 32'h8000_0000, 32'h0000_0001, 1);
        apply(4'd1, 32'hFFFF_FFF0, 32'hFFFF_FFF8, 1);
        // R8 same operands through non-trapping forms
        apply(4'd2, 32'h7FFF_FFFF, 32'h0000_0001, 1);
        apply(4'd2, 32'hFFFF_FFFF, 32'h0000_0001, 1);
        apply(4'd3, 32'h8000_0000, 32'h0000_0001, 1);
        // R6 borrow convention
        apply(4'd1, 32'd12, 32'd12, 1);
        apply(4'd3, 32'd0, 32'd1, 1);
        apply(4'd1, 32'd12, 32'd5, 1);
        // R2 / R5 logic with heavy upper bytes
        apply(4'd4, 32'hFFFF_FF03, 32'hFF00_FF01, 1);
        apply(4'd5, 32'h0F00_0000, 32'h0000_0007, 1);
        apply(4'd6, 32'h0000_0000, 32'h0000_0000, 1);
        // R3 shifts incl. upper shift bits set
        apply(4'd7, 32'h0000_0001, 32'h0000_001F, 1);
        apply(4'd8, 32'h8000_0000, 32'hFFFF_FFE5, 1);
        apply(4'd7, 32'h1234_5678, 32'h0000_0020, 1);
        // R11 undefined opcode
        apply(4'd12, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1);
        // R9 hold while idle after a trap
        apply(4'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1);
        apply(4'd4, 32'h0, 32'h0, 0);
        apply(4'd3, 32'h0, 32'h5, 0);

        // R10 reset wins over a valid overflowing add
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; op = 4'd0; a = 32'h7FFF_FFFF; b = 32'h1;
        @(posedge clk);
        #1;
        m_sign = 0; m_zero = 0; m_carry = 0; m_par = 0; m_trap = 0;
        check("R10", "reset priority", {27'd0, flag_sign_q, flag_zero_q, flag_carry_q, flag_parity_q, trap_q}, 32'd0);
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;

        for (int k = 0; k < 400; k++) begin
            logic [31:0] x, y;
            x = $urandom;
            y = $urandom;
            if (k % 5 == 0) y = x ^ 32'h8000_0000;
            apply(4'($urandom_range(0, 15)), x, y, ($urandom_range(0, 3) != 0));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule